// File: doc/BRIEF.md
# Late-Write Pipelined Memory with Write Bypass

This block is a synchronous single-port memory. A command (enable, direction, transfer width, address) is sampled on a rising clock edge. For a write, the data follows one cycle later on a separate input bus. The data is not written into the storage array at once. It is parked in a one-entry write buffer and reaches the array only when the next write's data is accepted. An address comparator checks every read against the parked entry. When a read hits the parked address, the buffered data is forwarded. A read issued right after a write to the same address therefore sees the new value.

Reads pass through two register stages: the command stage and the output data register. The data appears a fixed two cycles after the read command. Each access chooses single-rate or double-rate transfer. Inside the block, a double-rate access moves a double-width word per cycle: the lower half stands for the rising-edge beat and the upper half for the falling-edge beat. A single-rate access moves only the lower half. A per-beat valid flag marks which halves carry data. An output enable gates the read data bus combinationally, without waiting for a clock edge.

Top module: `lw_sram`

## Requirements
- R1: After a synchronous reset, both beat-valid flags are 0 and every location reads back as all zeros.
- R2: Write data is taken from `wr_data` in the cycle after the write command. Whatever is on `wr_data` during the command cycle itself is ignored.
- R3: A read command sampled in cycle N produces its data and beat flags in cycle N+2. The flags are `2'b01` for a single-rate read and `2'b11` for a double-rate read, and they are `2'b00` in every cycle that carries no read result.
- R4: A single-rate write (`ddr_sel`=0) updates only bits [DW-1:0] of the location. Bits [2*DW-1:DW] keep their previous contents.
- R5: A single-rate read returns the stored lower half on bits [DW-1:0] and drives bits [2*DW-1:DW] to zero.
- R6: A read whose address matches the write still held in the buffer returns the buffered data. For a buffered single-rate write, the upper half is merged from the array.
- R7: The buffered write is committed to the array when the next write's data is accepted. Reads in between do not disturb it, and the data is still returned correctly after later writes to other addresses.
- R8: A cycle with `cs_en`=0 performs neither a read nor a write, whatever `wr_en`, `addr` and `wr_data` are. A write still held in the buffer is kept.
- R9: While `out_en` is 0, `rd_data` is all zeros and the beat flags are unaffected. Raising `out_en` shows the registered data without waiting for a clock edge.
- R10: The falling-edge beat flag is never set without the rising-edge beat flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_en | input | 1 | Command enable; 0 makes the cycle idle |
| wr_en | input | 1 | 1 = write command, 0 = read command |
| ddr_sel | input | 1 | 1 = double-rate (both halves), 0 = single-rate (lower half) |
| addr | input | AW | Word address of the command |
| wr_data | input | 2*DW | Write data, presented one cycle after the write command |
| out_en | input | 1 | Combinational enable of the read data bus |
| rd_data | output | 2*DW | Read data; lower half = rising beat, upper half = falling beat |
| rd_beat_vld | output | 2 | Bit 0 = rising beat valid, bit 1 = falling beat valid |

## Verification
On every cycle, the embedded assertions check the following: the two-cycle read timing from the command stage to the beat flags, a zero upper half on single-rate results, the flag ordering, idle command stages after a deasserted enable, a stable write buffer between writes, and an array update that matches the committed entry. Data coherence itself can only be shown by the bench's scenarios, against an arithmetic model of the memory. These scenarios cover the read-after-write forwarding, the half-word merging of single-rate writes, the deferred commit order, the ignored data in the command cycle, and output gating.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    typedef enum logic {
        XFER_SDR = 1'b0,
        XFER_DDR = 1'b1
    } xfer_e;

    typedef enum logic [1:0] {
        BEATS_NONE = 2'b00,
        BEATS_RISE = 2'b01,
        BEATS_BOTH = 2'b11
    } beats_e;

    function automatic beats_e beats_for(input logic is_read, input xfer_e x);
        if (!is_read)            return BEATS_NONE;
        else if (x == XFER_DDR)  return BEATS_BOTH;
        else                     return BEATS_RISE;
    endfunction

endpackage

// File: rtl/lw_cmd_pipe.sv
module lw_cmd_pipe
    import lw_sram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_en,
    input  logic          wr_en,
    input  logic          ddr_sel,
    input  logic [AW-1:0] addr,
    output logic          s1_vld,
    output logic          s1_we,
    output xfer_e         s1_xfer,
    output logic [AW-1:0] s1_addr,
    output beats_e        s2_beats
);

    typedef struct packed {
        logic          vld;
        logic          we;
        xfer_e         xfer;
        logic [AW-1:0] addr;
    } stage_t;

    stage_t st1;

    // Stage 1: command capture
    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= '{vld: 1'b0, we: 1'b0, xfer: XFER_SDR, addr: '0};
        end else begin
            st1.vld  <= cs_en;
            st1.we   <= wr_en;
            st1.xfer <= xfer_e'(ddr_sel);
            st1.addr <= addr;
        end
    end

    // Stage 2: beat qualifiers for the read result
    always_ff @(posedge clk) begin
        if (rst) s2_beats <= BEATS_NONE;
        else     s2_beats <= beats_for(st1.vld && !st1.we, st1.xfer);
    end

    assign s1_vld  = st1.vld;
    assign s1_we   = st1.we;
    assign s1_xfer = st1.xfer;
    assign s1_addr = st1.addr;

    // R8: a disabled cycle leaves the command stage idle
    assert_idle_stage_R8: assert property (@(posedge clk) disable iff (rst)
        !cs_en |=> !s1_vld);

endmodule

// File: rtl/lw_wbuf.sv
module lw_wbuf #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld,
    input  logic [AW-1:0]   ld_addr,
    input  logic            ld_both,
    input  logic [2*DW-1:0] ld_data,
    input  logic [AW-1:0]   lk_addr,
    output logic            hit,
    output logic [2*DW-1:0] b_data,
    output logic            b_both,
    output logic            cm_we,
    output logic [AW-1:0]   cm_addr,
    output logic [2*DW-1:0] cm_data,
    output logic            cm_both
);

    typedef struct packed {
        logic            vld;
        logic [AW-1:0]   addr;
        logic            both;
        logic [2*DW-1:0] data;
    } entry_t;

    entry_t ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (ld) begin
            ent.vld  <= 1'b1;
            ent.addr <= ld_addr;
            ent.both <= ld_both;
            ent.data <= ld_data;
        end
    end

    // Comparator for the forwarding path
    assign hit     = ent.vld && (ent.addr == lk_addr);
    assign b_data  = ent.data;
    assign b_both  = ent.both;

    // The parked entry drains into the array as the next one arrives
    assign cm_we   = ld && ent.vld;
    assign cm_addr = ent.addr;
    assign cm_data = ent.data;
    assign cm_both = ent.both;

    // R8: the parked entry only changes when a write's data is accepted
    assert_buf_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(ent));

endmodule

// File: rtl/lw_store.sv
module lw_store #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [2*DW-1:0] wdata,
    input  logic            wboth,
    input  logic [AW-1:0]   raddr,
    output logic [2*DW-1:0] rdata
);

    localparam int WORDS = 1 << AW;

    logic [2*DW-1:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [DW-1:0] lo_q, hi_q;
        logic          sel;
        assign sel = we && (waddr == AW'(w));
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (sel) begin
                lo_q <= wdata[DW-1:0];
                if (wboth) hi_q <= wdata[2*DW-1:DW];
            end
        end
        assign words[w] = {hi_q, lo_q};
    end

    assign rdata = words[raddr];

    // R7: a committed entry lands in the addressed location
    assert_commit_lo_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we)) |->
            words[$past(waddr)][DW-1:0] == $past(wdata[DW-1:0]));

    // R4: a single-rate commit keeps the upper half
    assert_commit_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we) && !$past(wboth)) |->
            words[$past(waddr)][2*DW-1:DW] == $past(words[waddr][2*DW-1:DW]));

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_en,
    input  logic            wr_en,
    input  logic            ddr_sel,
    input  logic [AW-1:0]   addr,
    input  logic [2*DW-1:0] wr_data,
    input  logic            out_en,
    output logic [2*DW-1:0] rd_data,
    output logic [1:0]      rd_beat_vld
);

    localparam int WW = 2 * DW;

    logic          s1_vld, s1_we;
    xfer_e         s1_xfer;
    logic [AW-1:0] s1_addr;
    beats_e        s2_beats;

    logic          s1_rd, s1_wr;
    logic          hit, b_both;
    logic [WW-1:0] b_data;
    logic          cm_we, cm_both;
    logic [AW-1:0] cm_addr;
    logic [WW-1:0] cm_data;
    logic [WW-1:0] arr_word, merged, shaped, dout_q;

    lw_cmd_pipe #(.AW(AW)) cmd_i (
        .clk      (clk),
        .rst      (rst),
        .cs_en    (cs_en),
        .wr_en    (wr_en),
        .ddr_sel  (ddr_sel),
        .addr     (addr),
        .s1_vld   (s1_vld),
        .s1_we    (s1_we),
        .s1_xfer  (s1_xfer),
        .s1_addr  (s1_addr),
        .s2_beats (s2_beats)
    );

    assign s1_rd = s1_vld && !s1_we;
    assign s1_wr = s1_vld && s1_we;

    lw_wbuf #(.AW(AW), .DW(DW)) wbuf_i (
        .clk     (clk),
        .rst     (rst),
        .ld      (s1_wr),
        .ld_addr (s1_addr),
        .ld_both (s1_xfer == XFER_DDR),
        .ld_data (wr_data),
        .lk_addr (s1_addr),
        .hit     (hit),
        .b_data  (b_data),
        .b_both  (b_both),
        .cm_we   (cm_we),
        .cm_addr (cm_addr),
        .cm_data (cm_data),
        .cm_both (cm_both)
    );

    lw_store #(.AW(AW), .DW(DW)) store_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cm_we),
        .waddr (cm_addr),
        .wdata (cm_data),
        .wboth (cm_both),
        .raddr (s1_addr),
        .rdata (arr_word)
    );

    // Forwarding merge: the buffered lower half always wins on a hit,
    // the upper half only when the parked write was double-rate
    always_comb begin
        merged = arr_word;
        if (hit) begin
            merged[DW-1:0] = b_data[DW-1:0];
            if (b_both) merged[WW-1:DW] = b_data[WW-1:DW];
        end
        shaped = (s1_xfer == XFER_DDR) ? merged : {{DW{1'b0}}, merged[DW-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst)        dout_q <= '0;
        else if (s1_rd) dout_q <= shaped;
        else            dout_q <= '0;
    end

    assign rd_data     = out_en ? dout_q : '0;
    assign rd_beat_vld = s2_beats;

    // R3: a read in the command stage yields a rising beat next cycle
    assert_read_lat_R3: assert property (@(posedge clk) disable iff (rst)
        s1_rd |=> rd_beat_vld[0]);

    // R3: no result flags without a read one cycle earlier
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
        !s1_rd |=> rd_beat_vld == 2'b00);

    // R10: falling beat only together with rising beat
    assert_beat_order_R10: assert property (@(posedge clk) disable iff (rst)
        rd_beat_vld != 2'b10);

    // R5: single-rate results carry a zero upper half
    assert_sdr_upper_R5: assert property (@(posedge clk) disable iff (rst)
        rd_beat_vld == 2'b01 |-> rd_data[WW-1:DW] == '0);

endmodule

// File: tb/lw_sram_tb.sv
`timescale 1ns/1ps
module lw_sram_tb_top;

    localparam int AW    = 3;
    localparam int DW    = 8;
    localparam int WW    = 2 * DW;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_en = 1'b0, wr_en = 1'b0, ddr_sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic          out_en = 1'b1;
    logic [WW-1:0] rd_data;
    logic [1:0]    rd_beat_vld;

    always #2.5 clk = ~clk;

    lw_sram #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .cs_en(cs_en), .wr_en(wr_en), .ddr_sel(ddr_sel),
        .addr(addr), .wr_data(wr_data), .out_en(out_en),
        .rd_data(rd_data), .rd_beat_vld(rd_beat_vld)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int cyc    = 0;

    logic [WW-1:0] model [WORDS];
    logic [1:0]    exp_beats [4];
    logic [WW-1:0] exp_data  [4];
    string         exp_tag   [4];
    logic          pend_vld  = 1'b0;
    logic [WW-1:0] pend_data = '0;

    task automatic chk(input bit ok, input string tag,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [WW-1:0] pat(input int a, input int k);
        logic [DW-1:0] lo, hi;
        lo = DW'(a * 37 + k * 11 + 5);
        hi = DW'(a * 53 + k * 19 + 9);
        return {hi, lo};
    endfunction

    // One clock cycle: check results due now, then drive this cycle's command.
    task automatic step(input logic cs, input logic we, input logic ddr,
                        input int a, input logic [WW-1:0] d,
                        input logic oe, input string tag);
        int s;
        int t;
        @(negedge clk);
        out_en = oe;
        #1;
        s = cyc % 4;
        chk(rd_beat_vld != 2'b10, "R10", WW'(rd_beat_vld), WW'(2'b01));
        chk(rd_beat_vld == exp_beats[s], "R3", WW'(rd_beat_vld), WW'(exp_beats[s]));
        if (exp_beats[s] != 2'b00)
            chk(rd_data == (oe ? exp_data[s] : '0), oe ? exp_tag[s] : "R9",
                rd_data, oe ? exp_data[s] : '0);
        exp_beats[s] = 2'b00;
        cs_en   = cs;
        wr_en   = we;
        ddr_sel = ddr;
        addr    = AW'(a);
        // R2: junk on the bus during a command cycle with no data due
        wr_data = pend_vld ? pend_data : (WW'(16'hA55A) ^ WW'(cyc));
        pend_vld  = cs && we;
        pend_data = d;
        if (cs && we) begin
            if (ddr) model[a] = d;
            else     model[a][DW-1:0] = d[DW-1:0];
        end else if (cs) begin
            t = (cyc + 2) % 4;
            exp_beats[t] = ddr ? 2'b11 : 2'b01;
            exp_data[t]  = ddr ? model[a] : {{DW{1'b0}}, model[a][DW-1:0]};
            exp_tag[t]   = tag;
        end
        cyc++;
    endtask

    task automatic wr(input logic ddr, input int a, input logic [WW-1:0] d);
        step(1'b1, 1'b1, ddr, a, d, 1'b1, "R2");
    endtask

    task automatic rd(input logic ddr, input int a, input string tag);
        step(1'b1, 1'b0, ddr, a, '0, 1'b1, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 0, '0, 1'b1, "R8");
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        for (int i = 0; i < 4; i++) begin
            exp_beats[i] = 2'b00;
            exp_data[i]  = '0;
            exp_tag[i]   = "R3";
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_beat_vld == 2'b00, "R1", WW'(rd_beat_vld), '0);
        chk(rd_data == '0, "R1", rd_data, '0);
        rst = 1'b0;

        // R1: every location is zero after reset
        for (int a = 0; a < WORDS; a++) rd(1'b1, a, "R1");
        idle(2);

        // R2: double-rate fill, read back both widths
        for (int a = 0; a < WORDS; a++) wr(1'b1, a, pat(a, 1));
        for (int a = 0; a < WORDS; a++) rd(1'b1, a, "R2");
        for (int a = 0; a < WORDS; a++) rd(1'b0, a, "R5");
        idle(2);

        // R6: read immediately after writing the same address
        for (int a = 0; a < WORDS; a++) begin
            wr(1'b1, a, pat(a, 2));
            rd(1'b1, a, "R6");
            rd(1'b0, a, "R6");
        end
        idle(2);

        // R4: single-rate writes keep the upper half (forwarded and committed)
        for (int a = 0; a < WORDS; a++) begin
            wr(1'b0, a, pat(a, 3));
            rd(1'b1, a, "R4");
        end
        for (int a = 0; a < WORDS; a++) rd(1'b1, a, "R4");
        idle(2);

        // R7: deferred commit survives reads and later writes
        wr(1'b1, 3, pat(3, 4));
        for (int a = 0; a < WORDS; a++) rd(1'b1, a, "R7");
        wr(1'b1, 5, pat(5, 4));
        wr(1'b0, 3, pat(3, 5));
        wr(1'b1, 6, pat(6, 4));
        rd(1'b1, 3, "R7");
        rd(1'b1, 5, "R7");
        rd(1'b1, 6, "R7");

        // R8: disabled cycles neither write nor disturb the parked entry
        wr(1'b1, 2, pat(2, 6));
        step(1'b0, 1'b1, 1'b1, 4, pat(4, 9), 1'b1, "R8");
        step(1'b0, 1'b1, 1'b1, 2, pat(2, 9), 1'b1, "R8");
        step(1'b0, 1'b0, 1'b1, 4, '0, 1'b1, "R8");
        idle(4);
        rd(1'b1, 4, "R8");
        rd(1'b1, 2, "R8");
        wr(1'b1, 7, pat(7, 6));
        idle(1);
        rd(1'b1, 2, "R8");

        // R9: output gating, flags unaffected
        rd(1'b1, 1, "R9");
        rd(1'b1, 5, "R9");
        idle(0);
        step(1'b0, 1'b0, 1'b0, 0, '0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 0, '0, 1'b1, "R9");
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule